// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable model of a registered-address synchronous SRAM with two 9-bit byte lanes and a two-bit burst counter. A host strobe and a controller strobe both load a new address. Three chip-select inputs decide whether that load selects the device or deselects it. Once the device is selected, a separate step input walks the low address bits through a four-word window. Writes are decoded per lane from an all-lanes write input, a byte-write qualifier and one pick input per lane. Read data comes from the registered address. An output-drive input gates it onto the pins, and that gate is held off for the first cycle after the device leaves the deselected state. A doze input freezes the device and keeps the array contents.

The control is a four-state machine:
- `BSR_DESEL`: deselected, pins released.
- `BSR_FIRST`: first cycle after selection from a deselected or dozing state, with the drive masked.
- `BSR_LIVE`: selected, drive allowed.
- `BSR_SLEEP`: dozing.

The transitions are:
- **doze-in**: any state goes to `BSR_SLEEP` while doze is high.
- **wake**: `BSR_SLEEP` goes to `BSR_DESEL`, or to `BSR_FIRST` if the wake edge also loads.
- **select**: `BSR_DESEL` goes to `BSR_FIRST` on a load.
- **settle**: `BSR_FIRST` goes to `BSR_LIVE` on any edge that does not deselect.
- **reload**: `BSR_LIVE` stays in `BSR_LIVE` on a load.
- **drop**: `BSR_FIRST` or `BSR_LIVE` goes to `BSR_DESEL` on a deselecting strobe.

Top module: `burst_sram`

## Requirements
- R1: After reset the device is in `BSR_DESEL` and `rd_drive` is low, even with `drive_n` low.
- R2: On an edge where `ld_host_n` is low, `en_a_n` is low, `en_b` is high, `en_c_n` is low and `doze` is low, `addr` is captured. The word at that address then appears on `rd_data`.
- R3: When both strobes are low in the same edge, only the host strobe acts. A host-strobe load never writes, so write inputs on that edge are ignored.
- R4: The host strobe is ignored while `en_a_n` is high. The controller strobe is not gated by `en_a_n`, so with `en_a_n` high the controller strobe deselects the device.
- R5: The three selects are looked at only on an edge with a recognised strobe. A recognised strobe with any select inactive deselects the device and releases the pins. Changing the selects on other edges has no effect.
- R6: A load puts `addr[1:0]` into the burst counter. While the device is selected and no strobe is recognised, each edge with `burst_step_n` low adds one, wrapping from 3 to 0. The upper address bits never change without a load, and with `burst_step_n` high the counter holds.
- R7: `wr_all_n` low writes both lanes, whatever `wr_byte_n` and `lane_pick_n` are. A write happens on a controller-strobe load edge (at the new `addr`) or on a selected edge with no strobe (at the current burst address).
- R8: With `wr_all_n` high, lane g is written only when `wr_byte_n` is low and `lane_pick_n[g]` is low. Lane g is bits [9g+8:9g] of `wr_data` and `rd_data`.
- R9: `rd_data` always shows the word at the address registered by the last clock edge. Changing `addr` with no strobe does not alter it.
- R10: In `BSR_LIVE`, `rd_drive` follows `drive_n` without waiting for a clock: low drives, high releases.
- R11: In the first cycle after a load from the deselected state, `rd_drive` stays low even with `drive_n` low. After a load from `BSR_LIVE` the drive is not masked.
- R12: While `doze` is high, `rd_drive` is low at once, strobes and writes are ignored, and contents are kept. Leaving doze returns the device deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address presented with a strobe |
| ld_host_n | input | 1 | Host address strobe, active low, higher priority |
| ld_ctl_n | input | 1 | Controller address strobe, active low |
| en_a_n | input | 1 | Select A, active low; also gates the host strobe |
| en_b | input | 1 | Select B, active high |
| en_c_n | input | 1 | Select C, active low |
| burst_step_n | input | 1 | Burst counter step, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Per-lane write qualifier, active low |
| lane_pick_n | input | LANES | Per-lane write pick, active low |
| drive_n | input | 1 | Asynchronous output drive enable, active low |
| doze | input | 1 | Sleep request, active high |
| wr_data | input | LANES*LANE_W | Write data, lanes of LANE_W bits |
| rd_data | output | LANES*LANE_W | Word at the registered address |
| rd_drive | output | 1 | High when the data pins are driven, low when released |

## Verification
The bench targets the strobe corner cases. It presents both strobes at once with a write request, to catch a design that lets the controller win or lets a host load write. It presents the host strobe with select A inactive, where a wrong design would load a new address or fail to deselect through the controller strobe. The burst is stepped across the 3-to-0 wrap and then held, so a counter that carries into the upper bits or advances without a step shows up as a wrong read word. The tests also cover partial lane writes, the masked first drive cycle (a design that skips the mask drives one cycle early) and writes attempted during doze (a leaky design corrupts the array).

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;
    typedef enum logic [1:0] {
        BSR_DESEL = 2'd0,
        BSR_FIRST = 2'd1,
        BSR_LIVE  = 2'd2,
        BSR_SLEEP = 2'd3
    } bsr_state_e;
endpackage

// File: rtl/bsr_strobe_dec.sv
`timescale 1ns/1ps
// Resolves the two address strobes and the select qualification for one edge.
module bsr_strobe_dec (
    input  logic ld_host_n,
    input  logic ld_ctl_n,
    input  logic en_a_n,
    input  logic en_b,
    input  logic en_c_n,
    input  logic doze,
    input  logic selected,
    output logic load,
    output logic ctl_load,
    output logic desel,
    output logic burst_go
);
    logic host_hit;
    logic ctl_hit;
    logic any_hit;
    logic sel_ok;

    always_comb begin
        // select A gates the host strobe; the host strobe outranks the controller
        host_hit = !ld_host_n && !en_a_n;
        ctl_hit  = !ld_ctl_n && !host_hit;
        any_hit  = host_hit || ctl_hit;
        sel_ok   = !en_a_n && en_b && !en_c_n;
        load     = any_hit && sel_ok && !doze;
        ctl_load = ctl_hit && sel_ok && !doze;
        desel    = any_hit && !sel_ok && !doze;
        burst_go = selected && !any_hit && !doze;
    end
endmodule

// File: rtl/bsr_burst_ctr.sv
`timescale 1ns/1ps
// Registered address: fixed upper part plus a wrapping burst counter.
module bsr_burst_ctr #(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int UP_W = ADDR_W - BURST_W;

    logic [UP_W-1:0]    upper_q;
    logic [BURST_W-1:0] ctr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            ctr_q   <= '0;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:BURST_W];
            ctr_q   <= addr_in[BURST_W-1:0];
        end else if (step) begin
            ctr_q   <= ctr_q + BURST_W'(1);
        end
    end

    assign cur_addr = {upper_q, ctr_q};
endmodule

// File: rtl/bsr_lane_store.sv
`timescale 1ns/1ps
// One byte lane of the array: single write port, asynchronous read.
module bsr_lane_store #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/bsr_ctrl_fsm.sv
`timescale 1ns/1ps
// Select / first-cycle mask / doze state machine.
module bsr_ctrl_fsm
    import bsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       doze,
    input  logic       load,
    input  logic       desel,
    input  logic       drive_n,
    output bsr_state_e st,
    output logic       selected,
    output logic       rd_drive
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= BSR_DESEL;
        end else if (doze) begin
            st <= BSR_SLEEP;                        // doze-in
        end else begin
            unique case (st)
                BSR_DESEL: begin
                    if (load) st <= BSR_FIRST;      // select
                end
                BSR_FIRST, BSR_LIVE: begin
                    if (load)       st <= BSR_LIVE; // reload
                    else if (desel) st <= BSR_DESEL;// drop
                    else            st <= BSR_LIVE; // settle
                end
                BSR_SLEEP: begin
                    st <= load ? BSR_FIRST : BSR_DESEL; // wake
                end
                default: st <= BSR_DESEL;
            endcase
        end
    end

    always_comb begin
        selected = 1'b0;
        rd_drive = 1'b0;
        unique case (st)
            BSR_FIRST: selected = 1'b1;
            BSR_LIVE: begin
                selected = 1'b1;
                rd_drive = !drive_n && !doze;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
    import bsr_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 2,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ld_host_n,
    input  logic                    ld_ctl_n,
    input  logic                    en_a_n,
    input  logic                    en_b,
    input  logic                    en_c_n,
    input  logic                    burst_step_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_pick_n,
    input  logic                    drive_n,
    input  logic                    doze,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_drive
);
    bsr_state_e        st;
    logic              selected;
    logic              load;
    logic              ctl_load;
    logic              desel;
    logic              burst_go;
    logic              wr_cycle;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] waddr;

    bsr_strobe_dec u_dec (
        .ld_host_n (ld_host_n),
        .ld_ctl_n  (ld_ctl_n),
        .en_a_n    (en_a_n),
        .en_b      (en_b),
        .en_c_n    (en_c_n),
        .doze      (doze),
        .selected  (selected),
        .load      (load),
        .ctl_load  (ctl_load),
        .desel     (desel),
        .burst_go  (burst_go)
    );

    bsr_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .doze     (doze),
        .load     (load),
        .desel    (desel),
        .drive_n  (drive_n),
        .st       (st),
        .selected (selected),
        .rd_drive (rd_drive)
    );

    bsr_burst_ctr #(
        .ADDR_W  (ADDR_W),
        .BURST_W (BURST_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (burst_go && !burst_step_n),
        .addr_in  (addr),
        .cur_addr (cur_addr)
    );

    // controller loads write at the new address; burst edges at the current one
    assign wr_cycle = ctl_load || burst_go;
    assign waddr    = ctl_load ? addr : cur_addr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_we;
        assign lane_we = wr_cycle && (!wr_all_n || (!wr_byte_n && !lane_pick_n[g]));

        bsr_lane_store #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W)
        ) u_store (
            .clk   (clk),
            .we    (lane_we),
            .waddr (waddr),
            .wdata (wr_data[g*LANE_W +: LANE_W]),
            .raddr (cur_addr),
            .rdata (rd_data[g*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/bsr_checker.sv
`timescale 1ns/1ps
module bsr_checker
    import bsr_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ld_host_n,
    input logic              ld_ctl_n,
    input logic              en_a_n,
    input logic              en_b,
    input logic              en_c_n,
    input logic              burst_step_n,
    input logic              doze,
    input logic              rd_drive,
    input bsr_state_e        st,
    input logic [ADDR_W-1:0] cur_addr
);
    p_host_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && !ld_host_n && !en_a_n && en_b && !en_c_n) |=> (cur_addr == $past(addr)));

    p_host_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && ld_ctl_n && en_a_n && burst_step_n) |=> $stable(cur_addr));

    p_desel_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && ((!ld_host_n && !en_a_n) || !ld_ctl_n) && !(!en_a_n && en_b && !en_c_n))
        |=> !rd_drive);

    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ctl_n && (ld_host_n || en_a_n)) |=> $stable(cur_addr[ADDR_W-1:BURST_W]));

    p_first_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BSR_FIRST) |-> !rd_drive);

    p_doze_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        doze |=> !rd_drive);

    p_doze_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        doze |=> $stable(cur_addr));
endmodule

bind burst_sram bsr_checker #(
    .ADDR_W  (ADDR_W),
    .BURST_W (BURST_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .ld_host_n    (ld_host_n),
    .ld_ctl_n     (ld_ctl_n),
    .en_a_n       (en_a_n),
    .en_b         (en_b),
    .en_c_n       (en_c_n),
    .burst_step_n (burst_step_n),
    .doze         (doze),
    .rd_drive     (rd_drive),
    .st           (st),
    .cur_addr     (cur_addr)
);

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;
    localparam int AW    = 6;
    localparam int DW    = 18;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ld_host_n, ld_ctl_n, en_a_n, en_b, en_c_n;
    logic          burst_step_n, wr_all_n, wr_byte_n;
    logic [1:0]    lane_pick_n;
    logic          drive_n, doze;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          rd_drive;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [DW-1:0] model [DEPTH];

    burst_sram uut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .ld_host_n(ld_host_n), .ld_ctl_n(ld_ctl_n),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .burst_step_n(burst_step_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
        .lane_pick_n(lane_pick_n), .drive_n(drive_n), .doze(doze),
        .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rest();
        ld_host_n = 1'b1; ld_ctl_n = 1'b1;
        en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
        burst_step_n = 1'b1; wr_all_n = 1'b1; wr_byte_n = 1'b1;
        lane_pick_n = 2'b11;
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return {9'(a * 7 + 3), 9'(a ^ 'h155)};
    endfunction

    task automatic ctl_write(input int a, input logic [DW-1:0] d);
        rest(); addr = AW'(a); ld_ctl_n = 1'b0; wr_all_n = 1'b0; wr_data = d;
        tick(); model[a] = d; rest();
    endtask

    task automatic host_load(input int a);
        rest(); addr = AW'(a); ld_host_n = 1'b0;
        tick(); rest();
    endtask

    task automatic force_desel();
        rest(); ld_ctl_n = 1'b0; en_b = 1'b0;
        tick(); rest();
    endtask

    task automatic t_reset();
        chk("R1 drive after reset", 32'(rd_drive), 32'd0);
    endtask

    task automatic t_fill();
        drive_n = 1'b1;
        for (int a = 0; a < DEPTH; a++) ctl_write(a, pat(a));
        force_desel();
        host_load(10);
        chk("R7 controller-load global write", 32'(rd_data), 32'(model[10]));
    endtask

    task automatic t_host_read();
        force_desel();
        drive_n = 1'b0; #1;
        chk("R5 released after deselect", 32'(rd_drive), 32'd0);
        host_load(5);
        chk("R2 host load data", 32'(rd_data), 32'(model[5]));
        chk("R11 first cycle masked", 32'(rd_drive), 32'd0);
        addr = 6'd9; tick();
        chk("R9 data tied to registered address", 32'(rd_data), 32'(model[5]));
        chk("R10 drive low drives", 32'(rd_drive), 32'd1);
        drive_n = 1'b1; #1;
        chk("R10 drive high releases", 32'(rd_drive), 32'd0);
        drive_n = 1'b0; #1;
        host_load(7);
        chk("R11 no mask on reload", 32'(rd_drive), 32'd1);
        chk("R2 reload data", 32'(rd_data), 32'(model[7]));
    endtask

    task automatic t_priority();
        rest(); addr = 6'd20; ld_host_n = 1'b0; ld_ctl_n = 1'b0;
        wr_all_n = 1'b0; wr_data = ~model[20];
        tick(); rest();
        chk("R3 host wins, no write", 32'(rd_data), 32'(model[20]));
        tick();
        chk("R3 word intact", 32'(rd_data), 32'(model[20]));
    endtask

    task automatic t_gate();
        rest(); addr = 6'd3; ld_host_n = 1'b0; en_a_n = 1'b1;
        tick(); rest();
        chk("R4 host ignored data", 32'(rd_data), 32'(model[20]));
        chk("R4 host ignored drive", 32'(rd_drive), 32'd1);
        rest(); addr = 6'd3; ld_host_n = 1'b0; ld_ctl_n = 1'b0; en_a_n = 1'b1;
        tick(); rest();
        chk("R4 controller deselects", 32'(rd_drive), 32'd0);
    endtask

    task automatic t_enables();
        host_load(8);
        tick();
        rest(); en_b = 1'b0; en_c_n = 1'b1; burst_step_n = 1'b0;
        tick(); rest();
        chk("R5 selects ignored data", 32'(rd_data), 32'(model[9]));
        chk("R5 selects ignored drive", 32'(rd_drive), 32'd1);
        rest(); addr = 6'd30; ld_host_n = 1'b0; en_c_n = 1'b1;
        tick(); rest();
        chk("R5 select C deselects", 32'(rd_drive), 32'd0);
    endtask

    task automatic t_burst();
        host_load(14);
        chk("R6 start", 32'(rd_data), 32'(model[14]));
        burst_step_n = 1'b0; tick();
        chk("R6 step", 32'(rd_data), 32'(model[15]));
        tick();
        chk("R6 wrap", 32'(rd_data), 32'(model[12]));
        burst_step_n = 1'b1; tick();
        chk("R6 hold", 32'(rd_data), 32'(model[12]));
        burst_step_n = 1'b0; tick();
        chk("R6 step after hold", 32'(rd_data), 32'(model[13]));
        rest();
    endtask

    task automatic t_bytes();
        logic [DW-1:0] d1, d2, d3, d4;
        d1 = 18'h15A5A; d2 = 18'h0F0F3; d3 = 18'h3C3C3; d4 = 18'h2D2D2;
        drive_n = 1'b1;
        host_load(32);
        rest(); wr_byte_n = 1'b0; lane_pick_n = 2'b10; wr_data = d1; burst_step_n = 1'b0;
        tick(); model[32][8:0] = d1[8:0];
        rest(); wr_byte_n = 1'b0; lane_pick_n = 2'b01; wr_data = d2; burst_step_n = 1'b0;
        tick(); model[33][17:9] = d2[17:9];
        rest(); wr_byte_n = 1'b1; lane_pick_n = 2'b00; wr_data = d3; burst_step_n = 1'b0;
        tick();
        rest(); wr_all_n = 1'b0; wr_data = d4; burst_step_n = 1'b0;
        tick(); model[35] = d4;
        rest();
        drive_n = 1'b0;
        host_load(32);
        chk("R8 lane 0 only", 32'(rd_data), 32'(model[32]));
        burst_step_n = 1'b0; tick();
        chk("R8 lane 1 only", 32'(rd_data), 32'(model[33]));
        tick();
        chk("R8 qualifier high, no write", 32'(rd_data), 32'(model[34]));
        tick();
        chk("R7 global write both lanes", 32'(rd_data), 32'(model[35]));
        rest();
    endtask

    task automatic t_doze();
        host_load(40);
        tick();
        drive_n = 1'b0; #1;
        chk("R10 drive before doze", 32'(rd_drive), 32'd1);
        doze = 1'b1; #1;
        chk("R12 doze releases at once", 32'(rd_drive), 32'd0);
        rest(); addr = 6'd41; ld_ctl_n = 1'b0; wr_all_n = 1'b0; wr_data = ~model[41];
        tick(); rest();
        chk("R12 dozing drive", 32'(rd_drive), 32'd0);
        doze = 1'b0;
        tick();
        chk("R12 deselected after wake", 32'(rd_drive), 32'd0);
        host_load(41);
        tick();
        chk("R12 contents kept", 32'(rd_data), 32'(model[41]));
        chk("R12 drive after reselect", 32'(rd_drive), 32'd1);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rest(); drive_n = 1'b0; doze = 1'b0;
        addr = '0; wr_data = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_fill();
        t_host_read();
        t_priority();
        t_gate();
        t_enables();
        t_burst();
        t_bytes();
        t_doze();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule